// File: doc/BRIEF.md
# SIMD Carry-Less Multiply-Long Unit

This block multiplies polynomials over GF(2). Each source element is a polynomial whose coefficients are single bits. Partial products are merged with XOR, so no carry moves between bit positions. The unit takes two 128-bit source vectors. A half-select input picks either the low or the high 64 bits of each source as the operand vector. A size code then splits that half into lanes. Lane e of the first operand is multiplied only by lane e of the second. Each product lands in lane e of a 128-bit result, at twice the source element width.

Two lane layouts exist: eight 8-bit lanes with 16-bit products, or one 64-bit lane with a 128-bit product. The 64-bit layout is optional and is usable only while a feature-enable input is high. The product is built over 64 cycles, one multiplier bit per cycle. A valid/ready pair starts a job and a level `done` reports completion. Any other size code is refused, and so is the 64-bit code while the feature is off. A refused request raises a one-cycle illegal pulse and writes nothing. No flags or status exist beyond these outputs.

Top module: `clmul_long_unit`

## Requirements
- R1: While and after synchronous reset, `start_ready` is 1 and `done`, `illegal` and `result` are all 0.
- R2: With `elem_size` = 2'b00, bits [16e+15:16e] of `result` hold the carry-less product of byte e of the chosen first-operand half and byte e of the chosen second-operand half, for e = 0..7.
- R3: With `elem_size` = 2'b11 and `wide_en` = 1, `result` holds the 128-bit carry-less product of the two chosen 64-bit halves.
- R4: `hi_sel` = 0 takes operands from bits [63:0] of `src_a` and `src_b`. `hi_sel` = 1 takes them from bits [127:64]. The unselected half has no effect on the result.
- R5: A start is accepted on a rising edge where `start_valid` and `start_ready` are both 1 and the request is legal. `done` first reads 1 after the 64th rising edge following the accepting edge, and `start_ready` stays 0 in between.
- R6: `start_valid` and operand changes while a job runs are ignored. The running job's result is unaffected.
- R7: A request with `elem_size` 2'b01 or 2'b10, or 2'b11 with `wide_en` = 0, is not started. `illegal` is 1 for the single cycle after that edge. `result`, `done` and `start_ready` keep their values.
- R8: While `done` is 1 and no new job is accepted, `result` stays stable whatever the inputs do.
- R9: The top bit of every product lane is 0: bit 16e+15 in the 8-bit layout, bit 127 in the 64-bit layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Request to start a multiply |
| start_ready | output | 1 | Unit can accept a request (not busy) |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| hi_sel | input | 1 | 0: low halves, 1: high halves |
| elem_size | input | 2 | 00: 8-bit lanes, 11: one 64-bit lane, others reserved |
| wide_en | input | 1 | Enables the 64-bit lane layout |
| done | output | 1 | Result complete and held |
| illegal | output | 1 | One-cycle pulse after a refused request |
| result | output | 128 | Double-width product vector |

## Verification
A long sweep packs many distinct byte pairs into the 8-bit lanes. Each sweep alternates the half-select and fills the unused half with the complement of the pattern. A unit that ignored the select, or leaked bits across lanes, would show wrong products there. The sweep also covers zero operands, all-ones operands and single set bits at the most significant position. Those corners expose a unit that drops the last multiplier iteration or truncates the widened lane. Mid-run start attempts, refused size codes and a post-completion wait with changing inputs check that a busy or refused request does not corrupt a held result.

// File: rtl/clmul_pkg.sv
`timescale 1ns/1ps
package clmul_pkg;
    localparam int unsigned HALF_W      = 64;
    localparam int unsigned VEC_W       = 2 * HALF_W;
    localparam int unsigned LANE_W      = 8;
    localparam int unsigned N_LANES     = HALF_W / LANE_W;
    localparam int unsigned CNT_W       = $clog2(HALF_W);
    localparam int unsigned LSB_W       = $clog2(LANE_W);
    localparam int unsigned LANE_SEL_W  = $clog2(N_LANES);

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_RSV1  = 2'b01,
        SZ_RSV2  = 2'b10,
        SZ_DWORD = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_BUSY = 2'b01,
        ST_DONE = 2'b10
    } state_e;

    typedef struct packed {
        logic [HALF_W-1:0] mcand;
        logic [HALF_W-1:0] mplier;
        logic              wide;
    } job_t;

    function automatic logic [HALF_W-1:0] take_half(input logic [VEC_W-1:0] v, input logic hi);
        return hi ? v[VEC_W-1:HALF_W] : v[HALF_W-1:0];
    endfunction
endpackage

// File: rtl/clmul_decode.sv
`timescale 1ns/1ps
module clmul_decode
    import clmul_pkg::*;
(
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic             hi_sel,
    input  logic [1:0]       elem_size,
    input  logic             wide_en,
    output logic             legal,
    output job_t             job
);
    size_e sz;

    always_comb begin
        sz         = size_e'(elem_size);
        legal      = (sz == SZ_BYTE) || ((sz == SZ_DWORD) && wide_en);
        job.mcand  = take_half(src_a, hi_sel);
        job.mplier = take_half(src_b, hi_sel);
        job.wide   = (sz == SZ_DWORD);
    end
endmodule

// File: rtl/clmul_pp_gen.sv
`timescale 1ns/1ps
module clmul_pp_gen
    import clmul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [HALF_W-1:0] mcand,
    input  logic              bit_on,
    input  logic [CNT_W-1:0]  idx,
    input  logic              wide,
    output logic [VEC_W-1:0]  pp
);
    logic [VEC_W-1:0]   narrow_pp;
    logic [VEC_W-1:0]   wide_pp;
    logic [N_LANES-1:0] lane_hit;

    for (genvar e = 0; e < N_LANES; e++) begin : g_lane
        logic [2*LANE_W-1:0] lane_pp;
        always_comb begin
            if (bit_on && !wide && (idx[CNT_W-1:LSB_W] == LANE_SEL_W'(e)))
                lane_pp = {{LANE_W{1'b0}}, mcand[e*LANE_W +: LANE_W]} << idx[LSB_W-1:0];
            else
                lane_pp = '0;
        end
        assign narrow_pp[e*2*LANE_W +: 2*LANE_W] = lane_pp;
        assign lane_hit[e] = |lane_pp;
    end

    always_comb begin
        wide_pp = (bit_on && wide) ? ({{HALF_W{1'b0}}, mcand} << idx) : '0;
        pp      = wide ? wide_pp : narrow_pp;
    end

    // R2: in the byte layout a step touches at most one lane
    p_single_lane_r2: assert property (@(posedge clk) disable iff (rst)
        !wide |-> $onehot0(lane_hit));
endmodule

// File: rtl/clmul_ctrl.sv
`timescale 1ns/1ps
module clmul_ctrl
    import clmul_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_valid,
    input  logic             legal,
    output logic             accept,
    output logic             step,
    output logic [CNT_W-1:0] cnt,
    output logic             ready,
    output logic             done,
    output logic             illegal
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_W - 1);

    state_e state_q;
    logic   reject;

    always_comb begin
        ready  = (state_q != ST_BUSY);
        accept = start_valid && ready && legal;
        reject = start_valid && ready && !legal;
        step   = (state_q == ST_BUSY);
        done   = (state_q == ST_DONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt     <= '0;
            illegal <= 1'b0;
        end else begin
            illegal <= reject;
            if (accept) begin
                state_q <= ST_BUSY;
                cnt     <= '0;
            end else if (state_q == ST_BUSY) begin
                cnt <= cnt + 1'b1;
                if (cnt == LAST) state_q <= ST_DONE;
            end
        end
    end

    // R5: completion only follows the last iteration of a running job
    p_latency_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(state_q) == ST_BUSY) && ($past(cnt) == LAST));

    // R6: a request while busy does not restart or end the job early
    p_busy_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BUSY && start_valid && cnt != LAST) |=> (state_q == ST_BUSY) && (cnt == $past(cnt) + 1'b1));

    // R7: a refused request leaves the state untouched
    p_reject_state_r7: assert property (@(posedge clk) disable iff (rst)
        reject |=> (illegal && $stable(state_q)));
endmodule

// File: rtl/clmul_datapath.sv
`timescale 1ns/1ps
module clmul_datapath
    import clmul_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [CNT_W-1:0] cnt,
    input  job_t             job_in,
    output logic [VEC_W-1:0] acc,
    output logic             wide
);
    job_t             job_q;
    logic [VEC_W-1:0] pp;

    clmul_pp_gen u_pp (
        .clk    (clk),
        .rst    (rst),
        .mcand  (job_q.mcand),
        .bit_on (job_q.mplier[cnt]),
        .idx    (cnt),
        .wide   (job_q.wide),
        .pp     (pp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            job_q <= '0;
            acc   <= '0;
        end else if (load) begin
            job_q <= job_in;
            acc   <= '0;
        end else if (step) begin
            acc <= acc ^ pp;
        end
    end

    assign wide = job_q.wide;
endmodule

// File: rtl/clmul_long_unit.sv
`timescale 1ns/1ps
module clmul_long_unit
    import clmul_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_valid,
    output logic             start_ready,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic             hi_sel,
    input  logic [1:0]       elem_size,
    input  logic             wide_en,
    output logic             done,
    output logic             illegal,
    output logic [VEC_W-1:0] result
);
    logic             legal;
    job_t             job;
    logic             accept;
    logic             step;
    logic [CNT_W-1:0] cnt;
    logic             wide;
    logic [N_LANES-1:0] lane_top;

    clmul_decode u_dec (
        .src_a     (src_a),
        .src_b     (src_b),
        .hi_sel    (hi_sel),
        .elem_size (elem_size),
        .wide_en   (wide_en),
        .legal     (legal),
        .job       (job)
    );

    clmul_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_valid (start_valid),
        .legal       (legal),
        .accept      (accept),
        .step        (step),
        .cnt         (cnt),
        .ready       (start_ready),
        .done        (done),
        .illegal     (illegal)
    );

    clmul_datapath u_dp (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .step   (step),
        .cnt    (cnt),
        .job_in (job),
        .acc    (result),
        .wide   (wide)
    );

    for (genvar e = 0; e < N_LANES; e++) begin : g_top
        assign lane_top[e] = result[e*2*LANE_W + 2*LANE_W - 1];
    end

    // R8: a completed result holds until a new job is accepted
    p_hold_result_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !accept) |=> $stable(result));

    // R7: a refusal writes nothing
    p_no_write_r7: assert property (@(posedge clk) disable iff (rst)
        illegal |-> $stable(result));

    // R9: the widened product never uses its top bit
    p_top_bit_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (wide ? !result[VEC_W-1] : (lane_top == '0)));
endmodule

// File: tb/clmul_long_unit_tb.sv
`timescale 1ns/1ps
module clmul_long_unit_tb;
    logic         clk = 1'b0;
    logic         rst;
    logic         start_valid;
    logic         start_ready;
    logic [127:0] src_a, src_b;
    logic         hi_sel;
    logic [1:0]   elem_size;
    logic         wide_en;
    logic         done;
    logic         illegal;
    logic [127:0] result;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    clmul_long_unit u_dut (
        .clk(clk), .rst(rst), .start_valid(start_valid), .start_ready(start_ready),
        .src_a(src_a), .src_b(src_b), .hi_sel(hi_sel), .elem_size(elem_size),
        .wide_en(wide_en), .done(done), .illegal(illegal), .result(result)
    );

    function automatic logic [15:0] ref8(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] r = '0;
        for (int k = 0; k < 15; k++)
            for (int i = 0; i < 8; i++)
                if (k - i >= 0 && k - i < 8) r[k] = r[k] ^ (a[i] & b[k-i]);
        return r;
    endfunction

    function automatic logic [127:0] ref64(input logic [63:0] a, input logic [63:0] b);
        logic [127:0] r = '0;
        for (int k = 0; k < 127; k++)
            for (int i = 0; i < 64; i++)
                if (k - i >= 0 && k - i < 64) r[k] = r[k] ^ (a[i] & b[k-i]);
        return r;
    endfunction

    function automatic logic [127:0] expect_of(input logic [127:0] a, input logic [127:0] b,
                                              input logic hi, input logic [1:0] sz);
        logic [63:0] ah = hi ? a[127:64] : a[63:0];
        logic [63:0] bh = hi ? b[127:64] : b[63:0];
        logic [127:0] r = '0;
        if (sz == 2'b11) r = ref64(ah, bh);
        else for (int e = 0; e < 8; e++) r[e*16 +: 16] = ref8(ah[e*8 +: 8], bh[e*8 +: 8]);
        return r;
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [127:0] a, input logic [127:0] b, input logic hi,
                         input logic [1:0] sz, input logic en);
        @(negedge clk);
        src_a = a; src_b = b; hi_sel = hi; elem_size = sz; wide_en = en; start_valid = 1'b1;
        @(negedge clk);
        start_valid = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        while (!done && lat < 300) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_op(input string req, input logic [127:0] a, input logic [127:0] b,
                          input logic hi, input logic [1:0] sz);
        int lat;
        issue(a, b, hi, sz, 1'b1);
        wait_done(lat);
        chk("R5 latency", 128'(lat), 128'd64);
        chk(req, result, expect_of(a, b, hi, sz));
    endtask

    initial begin
        #(600_000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [127:0] a, b, held;
        int lat;
        rst = 1'b1; start_valid = 1'b0; src_a = '0; src_b = '0;
        hi_sel = 1'b0; elem_size = 2'b00; wide_en = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 ready", 128'(start_ready), 128'd1);
        chk("R1 done", 128'(done), 128'd0);
        chk("R1 illegal", 128'(illegal), 128'd0);
        chk("R1 result", result, 128'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready after release", 128'(start_ready), 128'd1);

        // R2/R4 sweep: byte lanes, both halves, garbage in the other half
        for (int k = 0; k < 256; k++) begin
            logic [63:0] pa, pb;
            for (int e = 0; e < 8; e++) begin
                int n = k * 8 + e;
                pa[e*8 +: 8] = 8'(n);
                pb[e*8 +: 8] = 8'((n >> 8) * 37 + n * 5 + 3);
            end
            if (k[0]) begin a = {pa, ~pa}; b = {pb, ~pb}; end
            else      begin a = {~pa, pa}; b = {~pb, pb}; end
            run_op(k[0] ? "R2 R4 hi bytes" : "R2 R4 lo bytes", a, b, k[0], 2'b00);
        end

        // R2 corners
        run_op("R2 zero", '0, {128{1'b1}}, 1'b0, 2'b00);
        run_op("R2 ones", {128{1'b1}}, {128{1'b1}}, 1'b1, 2'b00);
        run_op("R2 msb", {16{8'h80}}, {16{8'h80}}, 1'b0, 2'b00);
        run_op("R2 msb x ones", {16{8'h80}}, {128{1'b1}}, 1'b1, 2'b00);
        chk("R9 byte lane top bits", 128'(result[15] | result[31] | result[127]), 128'd0);

        // R3 corners and patterns
        run_op("R3 zero", {128{1'b1}}, '0, 1'b0, 2'b11);
        run_op("R3 ones", {128{1'b1}}, {128{1'b1}}, 1'b1, 2'b11);
        run_op("R3 msb", {64'h0, 64'h8000_0000_0000_0000}, {64'h0, 64'h8000_0000_0000_0000}, 1'b0, 2'b11);
        chk("R3 msb value", result, 128'h4000_0000_0000_0000_0000_0000_0000_0000);
        chk("R9 wide top bit", 128'(result[127]), 128'd0);
        for (int k = 0; k < 24; k++) begin
            logic [63:0] x = 64'h9E37_79B9_7F4A_7C15 * 64'(k + 1);
            logic [63:0] y = 64'hC2B2_AE3D_27D4_EB4F ^ (x << (k % 7));
            run_op(k[0] ? "R3 R4 hi wide" : "R3 R4 lo wide", {x, ~y}, {y, ~x}, k[0], 2'b11);
        end

        // R6: request during a run is ignored
        a = {64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210};
        b = {64'h0F0F_F0F0_3C3C_C3C3, 64'hA5A5_5A5A_9999_6666};
        issue(a, b, 1'b1, 2'b11, 1'b1);
        repeat (10) @(negedge clk);
        src_a = ~a; src_b = ~b; hi_sel = 1'b0; elem_size = 2'b00; start_valid = 1'b1;
        @(negedge clk);
        chk("R6 ready low while busy", 128'(start_ready), 128'd0);
        start_valid = 1'b0;
        wait_done(lat);
        chk("R6 result unaffected", result, expect_of(a, b, 1'b1, 2'b11));

        // R8: result holds while done
        held = result;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            src_a = src_a ^ 128'(i + 7); src_b = ~src_b; hi_sel = ~hi_sel;
        end
        chk("R8 done held", 128'(done), 128'd1);
        chk("R8 result held", result, held);

        // R7: refused requests
        for (int c = 0; c < 3; c++) begin
            logic [1:0] sz = (c == 0) ? 2'b01 : (c == 1) ? 2'b10 : 2'b11;
            issue(~a, ~b, 1'b0, sz, 1'b0);
            chk("R7 illegal pulse", 128'(illegal), 128'd1);
            chk("R7 done kept", 128'(done), 128'd1);
            chk("R7 ready kept", 128'(start_ready), 128'd1);
            chk("R7 result kept", result, held);
            @(negedge clk);
            chk("R7 illegal one cycle", 128'(illegal), 128'd0);
        end
        run_op("R7 legal after refusal", a, b, 1'b0, 2'b00);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule